// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor core that retires one instruction on every clock edge. It executes eight instructions: five register-to-register ALU operations (add, sub, and, or, set-less-than), a word load, a word store and a branch-if-equal. The core contains the program counter, a 32-entry general register file, an instruction ROM and a data RAM. Both memories take their contents from parameter images. The instruction ROM image is fixed. The data RAM is loaded from its image on reset and can be changed by stores after that.

In each cycle the core fetches the word at the PC and decodes it. It reads the two source registers, sign-extends the 16-bit immediate and runs the ALU, which produces either the operation result or a memory address. It then reads or writes the data RAM, steers the value to write back, and selects the next PC. A decoder produces a small struct of strobes that steers the datapath. A debug port shows the current PC and any register write that takes effect at the coming clock edge.

Top module: `sc_core`

## Requirements
- R1: While reset is high, the PC is 0. Reset also clears all registers to 0 and loads every data RAM word from the data image, with word i taken from image bits [32i+31:32i].
- R2: Any instruction other than a taken branch sets the next PC to PC + 4.
- R3: For opcode 0 with shift field 0, the core writes the result to rd (bits [15:11]). The sources are rs (bits [25:21]) and rt (bits [20:16]). Funct 0x20 is add, 0x22 is rs minus rt, 0x24 is and, 0x25 is or, and 0x2A is signed rs < rt, giving 1 or 0.
- R4: Opcode 0x23 (load) reads the data word at rs + sign-extended imm[15:0] and writes it to rt.
- R5: Opcode 0x2B (store) writes the value of rt to the data word at rs + sign-extended imm[15:0]. It does not write any register.
- R6: Opcode 0x04 (branch-if-equal) writes no register. When rs equals rt, the next PC is PC + 4 + (sign-extended imm << 2), and negative offsets branch backward. Otherwise the next PC is PC + 4.
- R7: Register 0 always reads as 0. A write to register 0 is dropped and is not reported on the debug port.
- R8: An unknown opcode, an unknown funct, or a nonzero shift field on opcode 0 writes neither registers nor memory.
- R9: The data RAM uses address bits [log2(words)+1:2]. Bits [1:0] are ignored, and higher bits wrap around the RAM.
- R10: dbgRegWe is high in the cycle of each register write that takes effect. In that cycle, dbgRegAddr and dbgRegData hold the destination and the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbgPc | output | 32 | Address of the instruction being executed |
| dbgRegWe | output | 1 | A register write takes effect at the next edge |
| dbgRegAddr | output | 5 | Destination register of that write |
| dbgRegData | output | 32 | Value being written |

## Verification
The bench runs one directed program and traces the PC and the register writes in every cycle. Three loads bring in positive and negative operands. With these, set-less-than can only pass with a signed compare, and subtraction checks operand order. A write to register 0 is followed by a read of register 0, which would show any leak. A store is followed by a load whose address has low bits set. A second load uses a negative offset and a third goes past the end of the RAM, so field extraction and wraparound are both exercised. The branches cover the not-taken case, a forward taken branch whose skipped slots would leave visible writes, and a backward branch to itself. Undefined encodings are followed by a read of the register they would have corrupted.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int REG_COUNT = 32;
  localparam int REG_AW    = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } aluOp_e;

  typedef struct packed {
    logic   regWrite;
    logic   regDstRd;
    logic   aluSrcImm;
    logic   memWrite;
    logic   memToReg;
    logic   branch;
    aluOp_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
(
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  aluOp_e      op,
  output logic [31:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {31'd0, $signed(a) < $signed(b)};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_core_pkg::*;
#(
  parameter int NREGS = REG_COUNT,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [31:0]   wData,
  input  logic [AW-1:0] rAddrA,
  input  logic [AW-1:0] rAddrB,
  output logic [31:0]   rDataA,
  output logic [31:0]   rDataB
);
  logic [31:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && wAddr != '0) begin
      regs[wAddr] <= wData;
    end
  end

  assign rDataA = (rAddrA == '0) ? '0 : regs[rAddrA];
  assign rDataB = (rAddrB == '0) ? '0 : regs[rAddrB];

  // R3/R4: an accepted write lands in the addressed entry
  assert_reg_write_R3: assert property (@(posedge clk) disable iff (rst)
    (we && wAddr != '0) |=> regs[$past(wAddr)] == $past(wData));

  // R7: entry 0 keeps its cleared value whatever is written
  assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[0] == '0);
endmodule

// File: rtl/sc_control.sv
module sc_control
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{regWrite: 1'b0, regDstRd: 1'b0, aluSrcImm: 1'b0, memWrite: 1'b0,
             memToReg: 1'b0, branch: 1'b0, aluOp: ALU_ADD};
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.regDstRd = 1'b1;
        if (shamt == '0) begin
          ctrl.regWrite = 1'b1;
          case (funct)
            FN_ADD:  ctrl.aluOp = ALU_ADD;
            FN_SUB:  ctrl.aluOp = ALU_SUB;
            FN_AND:  ctrl.aluOp = ALU_AND;
            FN_OR:   ctrl.aluOp = ALU_OR;
            FN_SLT:  ctrl.aluOp = ALU_SLT;
            default: ctrl.regWrite = 1'b0;
          endcase
        end
      end
      OP_LOAD: begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
        ctrl.memToReg  = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter logic [IMEM_WORDS*32-1:0] IMEM_IMAGE = '0,
  parameter logic [DMEM_WORDS*32-1:0] DMEM_IMAGE = '0,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  output logic [5:0]        opcode,
  output logic [4:0]        shamt,
  output logic [5:0]        funct,
  output logic [31:0]       dbgPc,
  output logic              dbgRegWe,
  output logic [REG_AW-1:0] dbgRegAddr,
  output logic [31:0]       dbgRegData
);
  logic [31:0] pc, pcPlus4, brTarget, pcNext;
  logic [31:0] instr, immExt, rsVal, rtVal, aluB, aluRes, memRd, wbData;
  logic [IAW-1:0] pcIdx;
  logic [IAW+4:0] romBit;
  logic [DAW-1:0] dIdx;
  logic [REG_AW-1:0] rsA, rtA, rdA, wAddr;
  logic takeBranch;
  logic [31:0] dmem [DMEM_WORDS];

  // fetch
  assign pcIdx  = IAW'(pc >> 2);
  assign romBit = {pcIdx, 5'd0};
  assign instr  = IMEM_IMAGE[romBit +: 32];

  // field split
  assign opcode = instr[31:26];
  assign rsA    = instr[25:21];
  assign rtA    = instr[20:16];
  assign rdA    = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign immExt = {{16{instr[15]}}, instr[15:0]};

  sc_regfile #(.NREGS(REG_COUNT)) regfile_i (
    .clk(clk), .rst(rst), .we(ctrl.regWrite), .wAddr(wAddr), .wData(wbData),
    .rAddrA(rsA), .rAddrB(rtA), .rDataA(rsVal), .rDataB(rtVal)
  );

  assign aluB = ctrl.aluSrcImm ? immExt : rtVal;

  sc_alu alu_i (.a(rsVal), .b(aluB), .op(ctrl.aluOp), .y(aluRes));

  // data memory
  assign dIdx  = DAW'(aluRes >> 2);
  assign memRd = dmem[dIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= DMEM_IMAGE[i*32 +: 32];
    end else if (ctrl.memWrite) begin
      dmem[dIdx] <= rtVal;
    end
  end

  // write-back
  assign wAddr  = ctrl.regDstRd ? rdA : rtA;
  assign wbData = ctrl.memToReg ? memRd : aluRes;

  // next PC
  assign pcPlus4    = pc + 32'd4;
  assign brTarget   = pcPlus4 + (immExt << 2);
  assign takeBranch = ctrl.branch && (aluRes == '0);
  assign pcNext     = takeBranch ? brTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign dbgPc      = pc;
  assign dbgRegWe   = ctrl.regWrite && (wAddr != '0);
  assign dbgRegAddr = wAddr;
  assign dbgRegData = wbData;

  assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == '0);

  assert_pc_seq_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl.branch |=> pc == $past(pc) + 32'd4);

  assert_beq_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rsVal == rtVal) |=>
      pc == $past(pc) + 32'd4 + {$past(immExt[29:0]), 2'b00});

  assert_beq_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rsVal != rtVal) |=> pc == $past(pc) + 32'd4);

  assert_store_data_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |=> dmem[$past(dIdx)] == $past(rtVal));

  assert_store_noreg_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !dbgRegWe);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter logic [IMEM_WORDS*32-1:0] IMEM_IMAGE = '0,
  parameter logic [DMEM_WORDS*32-1:0] DMEM_IMAGE = '0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbgPc,
  output logic        dbgRegWe,
  output logic [4:0]  dbgRegAddr,
  output logic [31:0] dbgRegData
);
  ctrl_t      ctrl;
  logic [5:0] opcode, funct;
  logic [4:0] shamt;

  sc_control control_i (.opcode(opcode), .shamt(shamt), .funct(funct), .ctrl(ctrl));

  sc_datapath #(
    .IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS),
    .IMEM_IMAGE(IMEM_IMAGE), .DMEM_IMAGE(DMEM_IMAGE)
  ) datapath_i (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .opcode(opcode), .shamt(shamt), .funct(funct),
    .dbgPc(dbgPc), .dbgRegWe(dbgRegWe), .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData)
  );
endmodule

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;
  localparam int IW = 64;
  localparam int DW = 64;

  function automatic logic [31:0] rt3(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] it3(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [IW*32-1:0] buildProg();
    logic [IW*32-1:0] p;
    p = '0;
    p[0*32  +: 32] = it3(6'h23, 0, 1, 16'd0);       // r1 = 5
    p[1*32  +: 32] = it3(6'h23, 0, 2, 16'd4);       // r2 = 3
    p[2*32  +: 32] = it3(6'h23, 0, 3, 16'd8);       // r3 = -7
    p[3*32  +: 32] = rt3(1, 2, 4, 6'h20);           // add
    p[4*32  +: 32] = rt3(2, 1, 5, 6'h22);           // sub
    p[5*32  +: 32] = rt3(1, 2, 6, 6'h24);           // and
    p[6*32  +: 32] = rt3(1, 2, 7, 6'h25);           // or
    p[7*32  +: 32] = rt3(3, 1, 8, 6'h2A);           // slt -7<5
    p[8*32  +: 32] = rt3(1, 3, 9, 6'h2A);           // slt 5<-7
    p[9*32  +: 32] = rt3(1, 2, 0, 6'h20);           // write r0
    p[10*32 +: 32] = rt3(0, 1, 10, 6'h25);          // r10 = r0|r1
    p[11*32 +: 32] = it3(6'h2B, 0, 4, 16'd20);      // mem[5] = 8
    p[12*32 +: 32] = it3(6'h23, 1, 11, 16'd16);     // addr 21 -> word 5
    p[13*32 +: 32] = it3(6'h23, 1, 12, 16'hFFFF);   // addr 4 -> word 1
    p[14*32 +: 32] = it3(6'h23, 0, 13, 16'd256);    // wraps to word 0
    p[15*32 +: 32] = it3(6'h04, 1, 2, 16'd5);       // not taken
    p[16*32 +: 32] = it3(6'h04, 1, 10, 16'd2);      // taken -> 76
    p[17*32 +: 32] = rt3(1, 1, 14, 6'h20);          // skipped
    p[18*32 +: 32] = rt3(1, 1, 14, 6'h20);          // skipped
    p[19*32 +: 32] = it3(6'h3F, 1, 14, 16'd4);      // undefined opcode
    p[20*32 +: 32] = rt3(1, 1, 14, 6'h3F);          // undefined funct
    p[21*32 +: 32] = {6'h00, 5'd1, 5'd1, 5'd14, 5'd3, 6'h20}; // shamt set
    p[22*32 +: 32] = rt3(14, 1, 14, 6'h20);         // r14 = r14 + r1
    p[23*32 +: 32] = it3(6'h04, 0, 0, 16'hFFFF);    // self loop
    return p;
  endfunction

  function automatic logic [DW*32-1:0] buildData();
    logic [DW*32-1:0] d;
    d = '0;
    d[0*32 +: 32] = 32'd5;
    d[1*32 +: 32] = 32'd3;
    d[2*32 +: 32] = 32'hFFFF_FFF9;
    d[3*32 +: 32] = 32'h0F0F_00FF;
    return d;
  endfunction

  localparam logic [IW*32-1:0] PROG = buildProg();
  localparam logic [DW*32-1:0] DATA = buildData();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] dbgPc, dbgRegData;
  logic        dbgRegWe;
  logic [4:0]  dbgRegAddr;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW), .IMEM_IMAGE(PROG), .DMEM_IMAGE(DATA)) dut_i (
    .clk(clk), .rst(rst), .dbgPc(dbgPc), .dbgRegWe(dbgRegWe),
    .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData)
  );

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Checks the current cycle at the falling edge, then advances one cycle.
  task automatic step(input string req, input logic [31:0] ePc, input bit eWe,
                      input logic [4:0] eAddr, input logic [31:0] eData);
    cmp(req, "pc", dbgPc, ePc);
    cmp(req, "regWe", {31'd0, dbgRegWe}, {31'd0, eWe});
    if (eWe) begin
      cmp(req, "regAddr", {27'd0, dbgRegAddr}, {27'd0, eAddr});
      cmp(req, "regData", dbgRegData, eData);
    end
    @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", "pc in reset", dbgPc, 32'd0);
    rst = 1'b0;
  endtask

  task automatic testLoads();
    step("R4", 32'd0, 1'b1, 5'd1, 32'd5);
    step("R4", 32'd4, 1'b1, 5'd2, 32'd3);
    step("R4", 32'd8, 1'b1, 5'd3, 32'hFFFF_FFF9);
  endtask

  task automatic testAlu();
    step("R3", 32'd12, 1'b1, 5'd4, 32'd8);
    step("R3", 32'd16, 1'b1, 5'd5, 32'hFFFF_FFFE);
    step("R3", 32'd20, 1'b1, 5'd6, 32'd1);
    step("R3", 32'd24, 1'b1, 5'd7, 32'd7);
    step("R3", 32'd28, 1'b1, 5'd8, 32'd1);
    step("R3", 32'd32, 1'b1, 5'd9, 32'd0);
  endtask

  task automatic testZeroReg();
    step("R7", 32'd36, 1'b0, 5'd0, 32'd0);
    step("R7", 32'd40, 1'b1, 5'd10, 32'd5);
  endtask

  task automatic testStoreAndAddr();
    step("R5", 32'd44, 1'b0, 5'd0, 32'd0);
    step("R9", 32'd48, 1'b1, 5'd11, 32'd8);
    step("R4", 32'd52, 1'b1, 5'd12, 32'd3);
    step("R9", 32'd56, 1'b1, 5'd13, 32'd5);
  endtask

  task automatic testBranches();
    step("R6", 32'd60, 1'b0, 5'd0, 32'd0);
    step("R6", 32'd64, 1'b0, 5'd0, 32'd0);
    cmp("R6", "taken target", dbgPc, 32'd76);
  endtask

  task automatic testUndefined();
    step("R8", 32'd76, 1'b0, 5'd0, 32'd0);
    step("R8", 32'd80, 1'b0, 5'd0, 32'd0);
    step("R8", 32'd84, 1'b0, 5'd0, 32'd0);
    // R1 cleared r14 and R8 left it untouched, so the sum is r1 alone
    step("R8", 32'd88, 1'b1, 5'd14, 32'd5);
  endtask

  task automatic testLoop();
    for (int k = 0; k < 3; k++) step("R6", 32'd92, 1'b0, 5'd0, 32'd0);
  endtask

  initial begin
    testReset();
    testLoads();
    testAlu();
    testZeroReg();
    testStoreAndAddr();
    testBranches();
    testUndefined();
    testLoop();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule